// File: doc/BRIEF.md
# SPI Host/Client Serial Port

This block is a full-duplex synchronous serial port. It can run as a host, which makes the serial clock, or as a client, which follows a clock from outside. Every word is exchanged through one 32-bit shift register. While one bit leaves on the data output, the bit from the far side is captured on the data input. The word size is chosen at run time: 8, 16 or 32 bits.

Software talks to the port over a small register bus with three locations: data, control and status. A write to the data location fills the transmit holding buffer. A read from the same location returns the receive holding buffer and empties it.

In host mode the serial clock is the system clock divided by 2*(N+1), where N is an 8-bit divisor. The clock pulses only while there is a word to send. The port can also drive the active-low select line itself, with a guard of one half period before the first edge and after the last edge. In client mode the incoming clock and select lines are passed through two-flop synchronizers, and edges are found after synchronization.

Top module: `spi_port`

## Requirements
- R1: After reset, status reads 0x1 (transmit empty only), control reads 0, `sck_o` is low, `ss_n_o` is high and `sck_oe` is low.
- R2: A transfer sends the transmit word MSB first on `sdo` and, at the same time, assembles the word arriving on `sdi`. The port launches data on the rising clock edge and samples on the falling edge (the clock idles low).
- R3: Control bits [3:2] pick the word size: 0 gives 8 bits, 1 gives 16 bits, 2 or 3 gives 32 bits. Bits above the word size read as zero in the received word, and the far side sees only the low bits of the transmit word.
- R4: Address 0 is shared by the two buffers. A write there fills the transmit buffer, and a read there returns the receive buffer and clears receive-full. The transmit buffer empties when the word is loaded into the shifter.
- R5: Control bit 0 selects host mode, and `sck_oe` follows it. In host mode each half period of `sck_o` lasts N+1 system clocks, where N is control bits [15:8].
- R6: In host mode `sck_o` stays low when no transmit word is pending.
- R7: `ss_n_oe` is high only when host mode and control bit 1 are both set. `ss_n_o` falls N+1 clocks before the first rising edge and rises N+1 clocks after the last falling edge. It stays low between back-to-back words.
- R8: In client mode the port shifts only on edges of `sck_i` while `ss_n_i` is low. Edges seen while `ss_n_i` is high are ignored, and raising `ss_n_i` drops a partial word.
- R9: The status word at address 2 holds: bit 0 transmit empty, bit 1 receive full, bit 2 busy, bit 3 overflow.
- R10: If a word completes while receive-full is still set, overflow is set and the buffered word is kept. Writing address 2 with bit 3 set clears overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 data, 1 control, 2 status |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (a read of data drains the receive buffer) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register |
| sck_o | output | 1 | Serial clock driven in host mode |
| sck_oe | output | 1 | Enable for the serial clock driver |
| sck_i | input | 1 | Serial clock received in client mode |
| ss_n_o | output | 1 | Active-low select driven in host mode |
| ss_n_oe | output | 1 | Enable for the select driver |
| ss_n_i | input | 1 | Active-low select received in client mode |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Enable for the serial data driver |
| sdi | input | 1 | Serial data in |

## Verification
Random words in each word size are exchanged in both modes against a bench model of the far end, using random divisors in host mode. These runs separate correct bit order and masking from shift or size errors. Directed host runs measure the select guard time and the half period in clocks. They also send two words back to back without reading the first, which tells a held select line and a protected receive buffer apart from one that is released or overwritten. Client runs toggle the clock while select is high and abandon a word part way through, which shows whether stray edges leak into the shifter.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  localparam int unsigned CTRL_DIV_W = 8;

  typedef enum logic [1:0] {
    WL_8   = 2'd0,
    WL_16  = 2'd1,
    WL_32  = 2'd2,
    WL_32B = 2'd3
  } wlen_e;

  typedef struct packed {
    logic [CTRL_DIV_W-1:0] div;
    logic [3:0]            spare;
    wlen_e                 wlen;
    logic                  sel_en;
    logic                  host_en;
  } spi_ctrl_t;

  typedef enum logic [2:0] {
    HS_IDLE,
    HS_LEAD,
    HS_HIGH,
    HS_LOW,
    HS_TAIL
  } hs_state_e;

  function automatic int unsigned wlen_bits(input wlen_e w);
    case (w)
      WL_8:    return 8;
      WL_16:   return 16;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/spi_port_hostseq.sv
module spi_port_hostseq
  import spi_port_pkg::*;
#(
  parameter int unsigned DIV_W = CTRL_DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tx_pend,
  input  logic             last_bit,
  input  logic [DIV_W-1:0] div,
  output logic             sck,
  output logic             ss_n,
  output logic             rise_ev,
  output logic             fall_ev,
  output logic             busy
);

  hs_state_e        state_q, state_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sck_q, sck_d;
  logic             ss_q, ss_d;
  logic             tick;

  assign tick = (cnt_q == div);

  always_comb begin
    state_d = state_q;
    cnt_d   = tick ? '0 : cnt_q + 1'b1;
    sck_d   = sck_q;
    ss_d    = ss_q;
    rise_ev = 1'b0;
    fall_ev = 1'b0;
    case (state_q)
      HS_IDLE: begin
        cnt_d = '0;
        sck_d = 1'b0;
        ss_d  = 1'b1;
        if (run && tx_pend) begin
          state_d = HS_LEAD;
          ss_d    = 1'b0;
        end
      end
      HS_LEAD, HS_LOW: begin
        if (tick) begin
          rise_ev = 1'b1;
          sck_d   = 1'b1;
          state_d = HS_HIGH;
        end
      end
      HS_HIGH: begin
        if (tick) begin
          fall_ev = 1'b1;
          sck_d   = 1'b0;
          state_d = last_bit ? HS_TAIL : HS_LOW;
        end
      end
      HS_TAIL: begin
        if (tick) begin
          if (tx_pend) begin
            rise_ev = 1'b1;
            sck_d   = 1'b1;
            state_d = HS_HIGH;
          end else begin
            ss_d    = 1'b1;
            state_d = HS_IDLE;
          end
        end
      end
      default: state_d = HS_IDLE;
    endcase
    if (!run) begin
      state_d = HS_IDLE;
      cnt_d   = '0;
      sck_d   = 1'b0;
      ss_d    = 1'b1;
      rise_ev = 1'b0;
      fall_ev = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      cnt_q   <= '0;
      sck_q   <= 1'b0;
      ss_q    <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sck_q   <= sck_d;
      ss_q    <= ss_d;
    end
  end

  assign sck  = sck_q;
  assign ss_n = ss_q;
  assign busy = (state_q != HS_IDLE);

endmodule

// File: rtl/spi_port_shifter.sv
module spi_port_shifter
  import spi_port_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rise_ev,
  input  logic         fall_ev,
  input  logic         abort,
  input  wlen_e        wlen,
  input  logic         tx_valid,
  input  logic [W-1:0] tx_word,
  input  logic         sdi,
  output logic         sdo,
  output logic         take_tx,
  output logic         done,
  output logic [W-1:0] rx_word,
  output logic         last_bit,
  output logic         active
);

  localparam int unsigned CNT_W = $clog2(W + 1);
  localparam int unsigned IDX_W = $clog2(W);

  logic [W-1:0]     shreg_q, shreg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sdo_q, sdo_d;
  logic [CNT_W-1:0] nbits;
  logic [IDX_W-1:0] top;
  logic [W-1:0]     mask;
  logic [W-1:0]     shifted;
  logic [W-1:0]     load_word;

  assign nbits     = CNT_W'(wlen_bits(wlen));
  assign top       = IDX_W'(nbits - CNT_W'(1));
  assign mask      = {W{1'b1}} >> (CNT_W'(W) - nbits);
  assign shifted   = {shreg_q[W-2:0], sdi};
  assign load_word = tx_valid ? tx_word : '0;

  always_comb begin
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    sdo_d   = sdo_q;
    take_tx = 1'b0;
    done    = 1'b0;
    if (abort) begin
      cnt_d = '0;
    end else if (rise_ev) begin
      if (cnt_q == '0) begin
        shreg_d = load_word;
        sdo_d   = load_word[top];
        cnt_d   = nbits;
        take_tx = tx_valid;
      end else begin
        sdo_d = shreg_q[top];
      end
    end else if (fall_ev && (cnt_q != '0)) begin
      shreg_d = shifted;
      cnt_d   = cnt_q - CNT_W'(1);
      done    = (cnt_q == CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      sdo_q   <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
      sdo_q   <= sdo_d;
    end
  end

  assign sdo      = sdo_q;
  assign rx_word  = shifted & mask;
  assign last_bit = (cnt_q == CNT_W'(1));
  assign active   = (cnt_q != '0);

endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              sck_i,
  output logic              ss_n_o,
  output logic              ss_n_oe,
  input  logic              ss_n_i,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              sdi
);

  localparam int unsigned CTRL_W = $bits(spi_ctrl_t);
  localparam logic [ADDR_W-1:0] ADR_DATA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADR_CTRL = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADR_STAT = ADDR_W'(2);
  localparam int unsigned STAT_OVF = 3;

  // reset: asynchronous assert, synchronous release
  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[SYNC_STAGES-1];

  // register state
  spi_ctrl_t         ctrl_q, ctrl_d;
  logic [DATA_W-1:0] tx_buf_q, tx_buf_d;
  logic              tx_valid_q, tx_valid_d;
  logic [DATA_W-1:0] rx_buf_q, rx_buf_d;
  logic              rx_full_q, rx_full_d;
  logic              ovf_q, ovf_d;

  logic wr_data, rd_drain, wr_ctrl, wr_stat;
  logic host_en;

  assign host_en  = ctrl_q.host_en;
  assign wr_data  = bus_we && (bus_addr == ADR_DATA);
  assign rd_drain = bus_re && (bus_addr == ADR_DATA);
  assign wr_ctrl  = bus_we && (bus_addr == ADR_CTRL);
  assign wr_stat  = bus_we && (bus_addr == ADR_STAT);

  // client-side pin synchronizers and edge detection
  logic sck_s, ss_n_s, sck_prev_q;
  logic ss_act, sck_rise_s, sck_fall_s;

  spi_port_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
    .clk(clk), .rst_n(rst_sn), .din(sck_i), .dout(sck_s)
  );

  spi_port_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ss (
    .clk(clk), .rst_n(rst_sn), .din(ss_n_i), .dout(ss_n_s)
  );

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) sck_prev_q <= 1'b0;
    else         sck_prev_q <= sck_s;
  end

  assign ss_act     = ~ss_n_s;
  assign sck_rise_s = sck_s & ~sck_prev_q;
  assign sck_fall_s = ~sck_s & sck_prev_q;

  // host clock and select sequencer
  logic hs_sck, hs_ss_n, hs_rise, hs_fall, hs_busy;
  logic sh_last;

  spi_port_hostseq #(.DIV_W(CTRL_DIV_W)) u_hostseq (
    .clk      (clk),
    .rst_n    (rst_sn),
    .run      (host_en),
    .tx_pend  (tx_valid_q),
    .last_bit (sh_last),
    .div      (ctrl_q.div),
    .sck      (hs_sck),
    .ss_n     (hs_ss_n),
    .rise_ev  (hs_rise),
    .fall_ev  (hs_fall),
    .busy     (hs_busy)
  );

  // shift engine shared by both modes
  logic              ev_rise, ev_fall, ev_abort;
  logic              sh_sdo, sh_take, sh_done, sh_active;
  logic [DATA_W-1:0] sh_rx_word;

  assign ev_rise  = host_en ? hs_rise  : (ss_act & sck_rise_s);
  assign ev_fall  = host_en ? hs_fall  : (ss_act & sck_fall_s);
  assign ev_abort = host_en ? ~hs_busy : ~ss_act;

  spi_port_shifter #(.W(DATA_W)) u_shifter (
    .clk      (clk),
    .rst_n    (rst_sn),
    .rise_ev  (ev_rise),
    .fall_ev  (ev_fall),
    .abort    (ev_abort),
    .wlen     (ctrl_q.wlen),
    .tx_valid (tx_valid_q),
    .tx_word  (tx_buf_q),
    .sdi      (sdi),
    .sdo      (sh_sdo),
    .take_tx  (sh_take),
    .done     (sh_done),
    .rx_word  (sh_rx_word),
    .last_bit (sh_last),
    .active   (sh_active)
  );

  // next-state for bus-visible registers
  always_comb begin
    ctrl_d     = wr_ctrl ? spi_ctrl_t'(bus_wdata[CTRL_W-1:0]) : ctrl_q;
    tx_buf_d   = wr_data ? bus_wdata : tx_buf_q;
    tx_valid_d = tx_valid_q;
    if (sh_take) tx_valid_d = 1'b0;
    if (wr_data) tx_valid_d = 1'b1;

    rx_buf_d  = rx_buf_q;
    rx_full_d = rx_full_q;
    ovf_d     = ovf_q;
    if (wr_stat && bus_wdata[STAT_OVF]) ovf_d = 1'b0;
    if (sh_done && (!rx_full_q || rd_drain)) begin
      rx_buf_d  = sh_rx_word;
      rx_full_d = 1'b1;
    end else if (sh_done) begin
      ovf_d = 1'b1;
    end else if (rd_drain) begin
      rx_full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ctrl_q     <= '0;
      tx_buf_q   <= '0;
      tx_valid_q <= 1'b0;
      rx_buf_q   <= '0;
      rx_full_q  <= 1'b0;
      ovf_q      <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_d;
      tx_buf_q   <= tx_buf_d;
      tx_valid_q <= tx_valid_d;
      rx_buf_q   <= rx_buf_d;
      rx_full_q  <= rx_full_d;
      ovf_q      <= ovf_d;
    end
  end

  // read mux
  logic              busy_any;
  logic [DATA_W-1:0] stat_word;

  assign busy_any  = host_en ? hs_busy : sh_active;
  assign stat_word = {{(DATA_W-4){1'b0}}, ovf_q, busy_any, rx_full_q, ~tx_valid_q};

  always_comb begin
    case (bus_addr)
      ADR_DATA: bus_rdata = rx_buf_q;
      ADR_CTRL: bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      ADR_STAT: bus_rdata = stat_word;
      default:  bus_rdata = '0;
    endcase
  end

  // pins
  assign sck_o   = hs_sck;
  assign sck_oe  = host_en;
  assign ss_n_o  = hs_ss_n;
  assign ss_n_oe = host_en & ctrl_q.sel_en;
  assign sdo     = sh_sdo;
  assign sdo_oe  = host_en | ss_act;

endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_en,
  input logic              sck_o,
  input logic              ss_n_o,
  input logic              ss_n_oe,
  input logic              done,
  input logic              rx_full,
  input logic              rd_drain,
  input logic [DATA_W-1:0] rx_buf,
  input logic              take_tx,
  input logic              wr_data,
  input logic              tx_valid,
  input logic              ss_act,
  input logic              active
);

  assert_ovf_keeps_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rx_full && !rd_drain) |=> $stable(rx_buf));

  assert_done_sets_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rx_full);

  assert_select_low_while_clock_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_en && ss_n_oe && sck_o) |-> !ss_n_o);

  assert_client_ignores_when_deselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_en && !ss_act) |=> !active);

  assert_load_empties_tx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_tx && !wr_data) |=> !tx_valid);

endmodule

bind spi_port spi_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .host_en  (host_en),
  .sck_o    (sck_o),
  .ss_n_o   (ss_n_o),
  .ss_n_oe  (ss_n_oe),
  .done     (sh_done),
  .rx_full  (rx_full_q),
  .rd_drain (rd_drain),
  .rx_buf   (rx_buf_q),
  .take_tx  (sh_take),
  .wr_data  (wr_data),
  .tx_valid (tx_valid_q),
  .ss_act   (ss_act),
  .active   (sh_active)
);

// File: tb/spi_port_bench.sv
module spi_port_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_CLI   = 6;

  logic        clk;
  logic        rst_n;
  logic [1:0]  bus_addr;
  logic        bus_we, bus_re;
  logic [31:0] bus_wdata, bus_rdata;
  logic        sck_o, sck_oe, sck_i;
  logic        ss_n_o, ss_n_oe, ss_n_i;
  logic        sdo, sdo_oe, sdi;
  logic        sdi_m, sdi_h, host_test;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  assign sdi = host_test ? sdi_m : sdi_h;

  spi_port u_spi_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_o(sck_o), .sck_oe(sck_oe),
    .sck_i(sck_i), .ss_n_o(ss_n_o), .ss_n_oe(ss_n_oe), .ss_n_i(ss_n_i),
    .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // far-end model used while the port is host
  logic [31:0] m_shift, m_rx;
  always @(posedge sck_o) if (host_test) begin
    sdi_m   = m_shift[31];
    m_shift = m_shift << 1;
  end
  always @(negedge sck_o) if (host_test) m_rx = {m_rx[30:0], sdo};

  // edge counters on the host pins
  int sck_rises = 0, ss_rises = 0;
  logic sck_p = 1'b0, ss_p = 1'b1;
  always @(negedge clk) begin
    if (sck_o && !sck_p) sck_rises++;
    if (ss_n_o && !ss_p) ss_rises++;
    sck_p = sck_o;
    ss_p  = ss_n_o;
  end

  function automatic int bits_of(input int wl);
    case (wl)
      0: return 8;
      1: return 16;
      default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] mask_of(input int wl);
    int nb = bits_of(wl);
    return (nb == 32) ? 32'hFFFF_FFFF : ((32'h1 << nb) - 32'h1);
  endfunction

  function automatic logic [31:0] mk_ctrl(input int div, input int wl, input bit sel, input bit host);
    return {16'h0, 8'(div), 4'h0, 2'(wl), sel, host};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_xfer(input int wl, input int div, input logic [31:0] t, input logic [31:0] s);
    int nb = bits_of(wl);
    logic [31:0] rd;
    host_test = 1'b1;
    bus_write(2'd1, mk_ctrl(div, wl, 1'b1, 1'b1));
    m_shift = s << (32 - nb);
    m_rx = '0;
    bus_write(2'd0, t);
    wait_clk((div + 1) * (2 * nb + 2) + 8);
    bus_read(2'd0, rd);
    chk("R2 host rx word", rd, s & mask_of(wl));
    chk("R3 far end saw tx word", m_rx & mask_of(wl), t & mask_of(wl));
    bus_read(2'd2, rd);
    chk("R4 status after drain", rd, 32'h1);
  endtask

  task automatic client_xfer(input int wl, input int nsend, input logic [31:0] hw, output logic [31:0] cap);
    int nb = bits_of(wl);
    host_test = 1'b0;
    cap = '0;
    @(negedge clk); ss_n_i = 1'b0;
    wait_clk(HALF_CLI);
    for (int i = 0; i < nsend; i++) begin
      sdi_h = hw[nb - 1 - i];
      sck_i = 1'b1;
      wait_clk(HALF_CLI);
      cap = {cap[30:0], sdo};
      sck_i = 1'b0;
      wait_clk(HALF_CLI);
    end
    ss_n_i = 1'b1;
    wait_clk(8);
  endtask

  task automatic client_full(input int wl, input logic [31:0] hw, input logic [31:0] dw);
    logic [31:0] cap, rd;
    bus_write(2'd1, mk_ctrl(0, wl, 1'b0, 1'b0));
    bus_write(2'd0, dw);
    client_xfer(wl, bits_of(wl), hw, cap);
    bus_read(2'd0, rd);
    chk("R8 client rx word", rd, hw & mask_of(wl));
    chk("R8 client tx word", cap, dw & mask_of(wl));
    bus_read(2'd2, rd);
    chk("R9 client status idle", rd, 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, t1, t2, s1, s2, cap;
    int n, r0, q0, seed;
    seed = $urandom(32'h5A17);
    bus_addr = '0; bus_we = 0; bus_re = 0; bus_wdata = '0;
    sck_i = 0; ss_n_i = 1; sdi_h = 0; sdi_m = 0; host_test = 1;
    m_shift = '0; m_rx = '0;
    rst_n = 0;
    wait_clk(4);
    rst_n = 1;
    wait_clk(4);

    // R1 reset state
    bus_read(2'd2, rd); chk("R1 status", rd, 32'h1);
    bus_read(2'd1, rd); chk("R1 control", rd, 32'h0);
    chk("R1 sck low", {31'b0, sck_o}, 32'h0);
    chk("R1 select high", {31'b0, ss_n_o}, 32'h1);
    chk("R1 sck_oe low", {31'b0, sck_oe}, 32'h0);

    // R6 idle clock with nothing queued, R5 oe, R7 select oe
    bus_write(2'd1, mk_ctrl(2, 0, 1'b0, 1'b1));
    chk("R7 select oe off", {31'b0, ss_n_oe}, 32'h0);
    chk("R5 sck_oe on", {31'b0, sck_oe}, 32'h1);
    r0 = sck_rises;
    wait_clk(60);
    chk("R6 no clock without data", 32'(sck_rises - r0), 32'h0);

    // R5/R7 directed timing, 8 bits, divisor 3
    host_test = 1'b1;
    bus_write(2'd1, mk_ctrl(3, 0, 1'b1, 1'b1));
    chk("R7 select oe on", {31'b0, ss_n_oe}, 32'h1);
    m_shift = 32'hC3 << 24; m_rx = '0;
    bus_write(2'd0, 32'h0000_005A);
    while (ss_n_o) @(negedge clk);
    n = 0; while (!sck_o) begin @(negedge clk); n++; end
    chk("R7 lead guard", 32'(n), 32'd4);
    n = 0; while (sck_o) begin @(negedge clk); n++; end
    chk("R5 half period", 32'(n), 32'd4);
    for (int k = 1; k < 8; k++) begin
      while (!sck_o) @(negedge clk);
      while (sck_o) @(negedge clk);
    end
    n = 0; while (!ss_n_o) begin @(negedge clk); n++; end
    chk("R7 tail guard", 32'(n), 32'd4);
    bus_read(2'd0, rd);
    chk("R2 directed rx", rd, 32'hC3);
    chk("R2 directed tx", m_rx & 32'hFF, 32'h5A);
    r0 = sck_rises;
    wait_clk(40);
    chk("R6 clock idle after word", 32'(sck_rises - r0), 32'h0);

    // R7/R10 back to back without draining
    t1 = 32'h96; t2 = 32'h3C; s1 = 32'hE1; s2 = 32'h7B;
    bus_write(2'd1, mk_ctrl(1, 0, 1'b1, 1'b1));
    m_shift = {s1[7:0], s2[7:0], 16'h0}; m_rx = '0;
    r0 = sck_rises; q0 = ss_rises;
    bus_write(2'd0, t1);
    while (!sck_o) @(negedge clk);
    bus_write(2'd0, t2);
    wait_clk(2 * (2 * 16 + 4) + 10);
    chk("R7 clocks for two words", 32'(sck_rises - r0), 32'd16);
    chk("R7 select held between words", 32'(ss_rises - q0), 32'd1);
    chk("R2 far end saw both words", m_rx & 32'hFFFF, {16'h0, t1[7:0], t2[7:0]});
    bus_read(2'd2, rd); chk("R10 overflow status", rd, 32'hB);
    bus_read(2'd0, rd); chk("R10 first word kept", rd, s1);
    bus_read(2'd2, rd); chk("R4 drain keeps overflow", rd, 32'h9);
    bus_write(2'd2, 32'h8);
    bus_read(2'd2, rd); chk("R10 overflow cleared", rd, 32'h1);

    // random host transfers in all sizes, R3 includes code 3
    for (int i = 0; i < 16; i++) begin
      host_xfer($urandom_range(3, 0), $urandom_range(4, 0), $urandom, $urandom);
    end

    // R8 client: edges with select high are ignored
    bus_write(2'd1, mk_ctrl(0, 0, 1'b0, 1'b0));
    host_test = 1'b0;
    bus_write(2'd0, 32'hA5);
    for (int i = 0; i < 10; i++) begin
      sdi_h = 1'b1; sck_i = 1'b1; wait_clk(HALF_CLI);
      sck_i = 1'b0; wait_clk(HALF_CLI);
    end
    bus_read(2'd2, rd);
    chk("R8 deselected edges ignored", rd, 32'h0);
    client_xfer(0, 8, 32'h4D, cap);
    chk("R8 first client word out", cap, 32'hA5);
    bus_read(2'd0, rd); chk("R8 first client word in", rd, 32'h4D);

    // R8 partial word dropped when select rises
    bus_write(2'd0, 32'hFF);
    client_xfer(0, 3, 32'hE0, cap);
    bus_read(2'd2, rd);
    chk("R8 partial word not stored", rd, 32'h1);
    client_full(1, 32'h1234, 32'hBEEF);

    // random client transfers
    for (int i = 0; i < 16; i++) begin
      client_full($urandom_range(3, 0), $urandom, $urandom);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule